// File: doc/BRIEF.md
# Program Memory Flash Controller

This block lets a small CPU erase, program and read a word-wide on-chip program memory through a byte-wide register bus. The memory array sits inside the block as plain synthesizable storage. Cycle latencies are modelled with counters, so software sees the same polling behaviour that a real array would give it. Software drives the block through a control byte, a two-byte address and four 16-bit data words. Each data word is written as a low byte and a high byte.

Erase and program are locked after reset. To open them, software requests a mode change and then writes three fixed key words into data words 1, 2 and 3, in that order, inside a bounded window. Every trigger bit in the control byte is set by software and cleared by hardware when its operation is done. Software polls these bits.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, every register offset reads 0x00 and erase and program are locked.
- R2: The register offsets are as follows. 0 is control. 1 and 2 are the address low and high bytes. 3 is unused and reads 0x00. Offsets 4+2n and 5+2n are the low and high bytes of data word n, for n from 0 to 3. In the control byte, bit 7 is the write enable, bits 6:4 are the mode, bit 3 is the mode-change trigger, bit 2 is the write-cycle trigger, bit 1 is the read enable and bit 0 is the read-cycle trigger. The write enable, mode and read enable bits read back as written.
- R3: A control write that sets the write enable, mode 110 and the mode-change trigger starts an unlock. Bit 3 then reads 1. Software writes the key words 0x0400, 0x090D and 0x40C3 to data words 1, 2 and 3 in that order. A key is judged when its high byte is written, together with the stored low byte. After the third key, bit 3 reads 0 and erase and program are allowed.
- R4: A wrong key word, or keys written in the wrong order, ends the unlock at once. Bit 3 then reads 0 and any later erase or program leaves the array unchanged.
- R5: All three keys must land within WINDOW_CYC clock cycles of the request. The default is 75000 cycles, which is 300 µs at 250 MHz. Otherwise bit 3 clears and the controller stays locked.
- R6: A write-cycle trigger in mode 001 erases the page that holds the address: PAGE_WORDS aligned words, 32 by default, are set to 0xFFFF. Bit 2 reads 1 until the erase ends.
- R7: A write-cycle trigger in mode 000 stores the bitwise AND of the old word and data word 0, so a program can only clear bits. Bit 2 clears after PROG_CYC cycles.
- R8: A read-cycle trigger with the read enable set and mode 011 loads the addressed word into data word 0 after READ_CYC cycles, and bit 0 then clears. A read trigger without both of those conditions is ignored: bit 0 reads 0 and data word 0 is unchanged.
- R9: Erase and program requests at or above address DEPTH-RSV_WORDS are ignored. This includes addresses beyond the array. The default limit is 0x3E0.
- R10: Any control write with the write enable at 0 locks the controller again at once.
- R11: Modes 101 and 111 are only recorded in the mode field. The mode-change trigger has no effect in any mode other than 110.
- R12: If a read cycle finishes in the same cycle as a bus write to data word 0, the word fetched from memory wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Register write byte |
| bus_rdata | output | 8 | Register read byte (combinational) |

## Verification
A read cycle writes its result into data word 0, and the CPU bus can write the same register in the same cycle. The bench starts a read, then idles exactly READ_CYC-1 cycles so that its byte write to data word 0 lands on the completion edge. It then checks that the full fetched word survives. An assertion also checks that data word 0 equals the fetched word on the cycle after every read completes.

// File: rtl/fpm_pkg.sv
// Package: shared encodings for the program memory flash controller.
// Assumes byte-wide register access and 16-bit memory words.
package fpm_pkg;

    typedef enum logic [2:0] {
        MODE_PROG   = 3'b000,
        MODE_ERASE  = 3'b001,
        MODE_READ   = 3'b011,
        MODE_RSV_A  = 3'b101,
        MODE_UNLOCK = 3'b110,
        MODE_RSV_B  = 3'b111
    } fpm_mode_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } fpm_op_e;

    localparam logic [3:0] REG_CTRL  = 4'd0;
    localparam logic [3:0] REG_ADRLO = 4'd1;
    localparam logic [3:0] REG_ADRHI = 4'd2;

    // Key word expected in data word idx (1..3) during an unlock.
    function automatic logic [15:0] key_for(input logic [1:0] idx);
        case (idx)
            2'd1:    key_for = 16'h0400;
            2'd2:    key_for = 16'h090D;
            2'd3:    key_for = 16'h40C3;
            default: key_for = 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/fpm_array.sv
// Module: word-wide program memory storage with one write port and two
// asynchronous read ports (read-modify-write path and read-cycle path).
// Assumes: contents are not reset; software erases before it relies on data.
module fpm_array #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [15:0]       wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [15:0]       rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [15:0]       rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [15:0] mem [DEPTH];

    // Purpose: commit one word per cycle when the engine asks for it.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/fpm_unlock.sv
// Module: write-access unlock sequencer. A request opens a window of
// WINDOW_CYC cycles in which three key words must arrive in order.
// Assumes: key_wr pulses once per high-byte write to data words 1..3.
module fpm_unlock
    import fpm_pkg::*;
#(
    parameter int WINDOW_CYC = 75000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        relock,
    input  logic        key_wr,
    input  logic [1:0]  key_idx,
    input  logic [15:0] key_word,
    output logic        pending,
    output logic        unlocked
);
    localparam int TW = $clog2(WINDOW_CYC + 1);
    localparam logic [TW-1:0] T_LAST = TW'(WINDOW_CYC - 1);

    logic [TW-1:0] timer;
    logic [1:0]    step;
    logic          key_ok;

    // Purpose: judge the incoming key against the expected step.
    always_comb key_ok = (key_idx == step) && (key_word == key_for(step));

    // Purpose: track the pending window, the key step and the lock state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending  <= 1'b0;
            unlocked <= 1'b0;
            step     <= 2'd0;
            timer    <= '0;
        end else if (relock) begin
            pending  <= 1'b0;
            unlocked <= 1'b0;
        end else if (start) begin
            pending  <= 1'b1;
            unlocked <= 1'b0;
            step     <= 2'd1;
            timer    <= '0;
        end else if (pending) begin
            if (key_wr) begin
                if (key_ok) begin
                    if (step == 2'd3) begin
                        pending  <= 1'b0;
                        unlocked <= 1'b1;
                    end else begin
                        step <= step + 2'd1;
                    end
                end else begin
                    pending <= 1'b0;
                end
            end else if (timer == T_LAST) begin
                pending <= 1'b0;
            end else begin
                timer <= timer + 1'b1;
            end
        end
    end

    assert_window_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> (int'(timer) < WINDOW_CYC));

    assert_unlock_by_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> ($past(pending) && $past(key_wr)));

endmodule

// File: rtl/fpm_engine.sv
// Module: cycle sequencer for erase, program and read operations.
// Erase walks one word per cycle over the page; program is a
// read-modify-write AND committed on its last cycle; read loads after
// READ_CYC cycles. Assumes go pulses are ignored while the path is busy.
module fpm_engine
    import fpm_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int PAGE_WORDS = 32,
    parameter int RSV_WORDS  = 32,
    parameter int PROG_CYC   = 6,
    parameter int READ_CYC   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic              rd_go,
    input  logic [2:0]        mode,
    input  logic [15:0]       addr,
    input  logic [15:0]       wdata,
    input  logic              unlocked,
    output logic              wr_busy,
    output logic              rd_busy,
    output logic              rd_done,
    output logic [15:0]       rd_word,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [15:0]       mem_wdata,
    output logic [ADDR_W-1:0] rmw_raddr,
    input  logic [15:0]       rmw_rdata,
    output logic [ADDR_W-1:0] rd_raddr,
    input  logic [15:0]       rd_rdata
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LIMIT  = DEPTH - RSV_WORDS;
    localparam int PG_W   = $clog2(PAGE_WORDS);
    localparam int WMAX   = (PAGE_WORDS > PROG_CYC) ? PAGE_WORDS : PROG_CYC;
    localparam int CW     = $clog2(WMAX) + 1;
    localparam int RW     = $clog2(READ_CYC) + 1;
    localparam logic [CW-1:0] PAGE_LAST = CW'(PAGE_WORDS - 1);
    localparam logic [CW-1:0] PROG_LAST = CW'(PROG_CYC - 1);
    localparam logic [RW-1:0] READ_LAST = RW'(READ_CYC - 1);
    localparam logic [16:0]   LIMIT17   = 17'(LIMIT);
    localparam logic [16:0]   DEPTH17   = 17'(DEPTH);

    fpm_op_e         wop;
    logic [CW-1:0]   wcnt;
    logic [15:0]     waddr_q;
    logic [15:0]     wdata_q;
    logic            wr_last;
    logic            in_range;
    logic [RW-1:0]   rcnt;
    logic [15:0]     raddr_q;

    // Purpose: decide when the current write-path cycle is the last one.
    always_comb wr_last = (wop == OP_ERASE) ? (wcnt == PAGE_LAST) : (wcnt == PROG_LAST);

    // Purpose: flag targets that lie below the reserved top of the array.
    always_comb in_range = ({1'b0, waddr_q} < LIMIT17);

    // Purpose: sequence erase and program cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_busy <= 1'b0;
            wcnt    <= '0;
            wop     <= OP_NONE;
            waddr_q <= '0;
            wdata_q <= '0;
        end else if (wr_go && !wr_busy) begin
            wr_busy <= 1'b1;
            wcnt    <= '0;
            waddr_q <= addr;
            wdata_q <= wdata;
            case (mode)
                MODE_PROG:  wop <= OP_PROG;
                MODE_ERASE: wop <= OP_ERASE;
                default:    wop <= OP_NONE;
            endcase
        end else if (wr_busy) begin
            if (wr_last) wr_busy <= 1'b0;
            else         wcnt    <= wcnt + 1'b1;
        end
    end

    // Purpose: drive the array write port; locked or out-of-range does nothing.
    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = waddr_q[ADDR_W-1:0];
        mem_wdata = rmw_rdata & wdata_q;
        if (wop == OP_ERASE) begin
            mem_waddr = {waddr_q[ADDR_W-1:PG_W], wcnt[PG_W-1:0]};
            mem_wdata = 16'hFFFF;
        end
        if (wr_busy && unlocked && in_range) begin
            mem_we = (wop == OP_ERASE) || ((wop == OP_PROG) && wr_last);
        end
    end

    assign rmw_raddr = waddr_q[ADDR_W-1:0];

    // Purpose: sequence read cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_busy <= 1'b0;
            rcnt    <= '0;
            raddr_q <= '0;
        end else if (rd_go && !rd_busy) begin
            rd_busy <= 1'b1;
            rcnt    <= '0;
            raddr_q <= addr;
        end else if (rd_busy) begin
            if (rcnt == READ_LAST) rd_busy <= 1'b0;
            else                   rcnt    <= rcnt + 1'b1;
        end
    end

    assign rd_raddr = raddr_q[ADDR_W-1:0];
    assign rd_done  = rd_busy && (rcnt == READ_LAST);
    assign rd_word  = ({1'b0, raddr_q} < DEPTH17) ? rd_rdata : 16'hFFFF;

    assert_wr_path_settles_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_busy && wr_last) |=> !wr_busy);

endmodule

// File: rtl/flash_prog_ctrl.sv
// Module: top of the program memory flash controller. Decodes the byte
// register bus, holds control, address and data words, and connects the
// unlock sequencer, the cycle engine and the storage array.
// Assumes: one register write per cycle; reads are combinational.
module flash_prog_ctrl
    import fpm_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int PAGE_WORDS = 32,
    parameter int RSV_WORDS  = 32,
    parameter int PROG_CYC   = 6,
    parameter int READ_CYC   = 4,
    parameter int WINDOW_CYC = 75000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_we,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int LIMIT = DEPTH - RSV_WORDS;
    localparam int NDR   = 4;

    logic        wen_q;
    logic [2:0]  mode_q;
    logic        rden_q;
    logic [15:0] addr_q;
    logic [15:0] dr [NDR];

    logic        ctrl_wr, start_unlock, relock, wr_go, rd_go;
    logic        dr_hit;
    logic [2:0]  dr_n_full;
    logic [1:0]  dr_n;
    logic        key_wr;
    logic [15:0] key_word;
    logic        pending, unlocked;
    logic        wr_busy, rd_busy, rd_done;
    logic [15:0] rd_word;
    logic        mem_we;
    logic [ADDR_W-1:0] mem_waddr, rmw_raddr, rd_raddr;
    logic [15:0] mem_wdata, rmw_rdata, rd_rdata;

    // Purpose: decode control-byte writes into requests.
    always_comb begin
        ctrl_wr      = bus_we && (bus_addr == REG_CTRL);
        start_unlock = ctrl_wr && bus_wdata[7] && bus_wdata[3] && (bus_wdata[6:4] == MODE_UNLOCK);
        relock       = ctrl_wr && !bus_wdata[7];
        wr_go        = ctrl_wr && bus_wdata[2];
        rd_go        = ctrl_wr && bus_wdata[0] && bus_wdata[1] && (bus_wdata[6:4] == MODE_READ);
    end

    // Purpose: decode data-word offsets and build the key candidate.
    always_comb begin
        dr_hit    = (bus_addr >= 4'd4) && (bus_addr <= 4'd11);
        dr_n_full = bus_addr[3:1] - 3'd2;
        dr_n      = dr_n_full[1:0];
        key_wr    = bus_we && dr_hit && bus_addr[0] && (dr_n != 2'd0);
        key_word  = {bus_wdata, dr[dr_n][7:0]};
    end

    // Purpose: hold the software-owned control fields and the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen_q  <= 1'b0;
            mode_q <= 3'b000;
            rden_q <= 1'b0;
            addr_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == REG_CTRL) begin
                wen_q  <= bus_wdata[7];
                mode_q <= bus_wdata[6:4];
                rden_q <= bus_wdata[1];
            end
            if (bus_addr == REG_ADRLO) addr_q[7:0]  <= bus_wdata;
            if (bus_addr == REG_ADRHI) addr_q[15:8] <= bus_wdata;
        end
    end

    // Purpose: hold the data words; a finishing read overrides a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NDR; i++) dr[i] <= '0;
        end else begin
            if (bus_we && dr_hit) begin
                if (bus_addr[0]) dr[dr_n][15:8] <= bus_wdata;
                else             dr[dr_n][7:0]  <= bus_wdata;
            end
            if (rd_done) dr[0] <= rd_word;
        end
    end

    // Purpose: register read multiplexer; trigger bits reflect live status.
    always_comb begin
        bus_rdata = 8'h00;
        case (bus_addr)
            REG_CTRL:  bus_rdata = {wen_q, mode_q, pending, wr_busy, rden_q, rd_busy};
            REG_ADRLO: bus_rdata = addr_q[7:0];
            REG_ADRHI: bus_rdata = addr_q[15:8];
            default: begin
                if (dr_hit) bus_rdata = bus_addr[0] ? dr[dr_n][15:8] : dr[dr_n][7:0];
            end
        endcase
    end

    fpm_unlock #(
        .WINDOW_CYC (WINDOW_CYC)
    ) u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_unlock),
        .relock   (relock),
        .key_wr   (key_wr),
        .key_idx  (dr_n),
        .key_word (key_word),
        .pending  (pending),
        .unlocked (unlocked)
    );

    fpm_engine #(
        .ADDR_W     (ADDR_W),
        .PAGE_WORDS (PAGE_WORDS),
        .RSV_WORDS  (RSV_WORDS),
        .PROG_CYC   (PROG_CYC),
        .READ_CYC   (READ_CYC)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_go     (wr_go),
        .rd_go     (rd_go),
        .mode      (bus_wdata[6:4]),
        .addr      (addr_q),
        .wdata     (dr[0]),
        .unlocked  (unlocked),
        .wr_busy   (wr_busy),
        .rd_busy   (rd_busy),
        .rd_done   (rd_done),
        .rd_word   (rd_word),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .rmw_raddr (rmw_raddr),
        .rmw_rdata (rmw_rdata),
        .rd_raddr  (rd_raddr),
        .rd_rdata  (rd_rdata)
    );

    fpm_array #(
        .ADDR_W (ADDR_W)
    ) u_array (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .raddr_a (rmw_raddr),
        .rdata_a (rmw_rdata),
        .raddr_b (rd_raddr),
        .rdata_b (rd_rdata)
    );

    assert_write_needs_unlock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> unlocked);

    assert_write_below_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (int'(mem_waddr) < LIMIT));

    assert_relock_now_R10: assert property (@(posedge clk) disable iff (!rst_n)
        relock |=> !unlocked);

    assert_unlock_needs_wen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked |-> wen_q);

    assert_read_self_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_busy);

    assert_read_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> (dr[0] == $past(rd_word)));

endmodule

// File: tb/flash_prog_ctrl_tb.sv
module flash_prog_ctrl_tb;

    localparam int WIN   = 40;
    localparam int RDC   = 4;
    localparam int WDOG  = 150000;

    typedef struct packed {
        logic [3:0] a;
        logic [7:0] d;
        logic [7:0] e;
        logic       r11;
    } vec_t;

    // Register write / read-back vectors (R2, and R11 where flagged).
    localparam vec_t VECS [12] = '{
        '{4'd1,  8'h1F, 8'h1F, 1'b0},
        '{4'd2,  8'h03, 8'h03, 1'b0},
        '{4'd4,  8'h64, 8'h64, 1'b0},
        '{4'd5,  8'h5A, 8'h5A, 1'b0},
        '{4'd6,  8'hA5, 8'hA5, 1'b0},
        '{4'd9,  8'h3C, 8'h3C, 1'b0},
        '{4'd11, 8'h81, 8'h81, 1'b0},
        '{4'd3,  8'hFF, 8'h00, 1'b0},
        '{4'd0,  8'h32, 8'h32, 1'b0},
        '{4'd0,  8'h70, 8'h70, 1'b1},
        '{4'd0,  8'h58, 8'h50, 1'b1},
        '{4'd0,  8'h00, 8'h00, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    flash_prog_ctrl #(
        .WINDOW_CYC (WIN),
        .READ_CYC   (RDC)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr16(input logic [3:0] a, input logic [15:0] w);
        wr(a, w[7:0]);
        wr(a + 4'd1, w[15:8]);
    endtask

    task automatic poll_clear(input int bitn, input string tag);
        logic [7:0] v;
        for (int i = 0; i < 200; i++) begin
            rd(4'd0, v);
            if (!v[bitn]) return;
        end
        chk(tag, int'(v[bitn]), 0);
    endtask

    task automatic set_addr(input logic [15:0] a);
        wr16(4'd1, a);
    endtask

    task automatic do_erase(input logic [15:0] a);
        set_addr(a); wr(4'd0, 8'h94); poll_clear(2, "R6 erase completes");
    endtask

    task automatic do_prog(input logic [15:0] a, input logic [15:0] w);
        wr16(4'd4, w); set_addr(a); wr(4'd0, 8'h84); poll_clear(2, "R7 program completes");
    endtask

    task automatic do_read(input logic [15:0] a, output logic [15:0] w);
        logic [7:0] lo, hi;
        set_addr(a); wr(4'd0, 8'hB3); poll_clear(0, "R8 read completes");
        rd(4'd4, lo); rd(4'd5, hi);
        w = {hi, lo};
    endtask

    task automatic unlock_ok();
        wr(4'd0, 8'hE8);
        wr16(4'd6, 16'h0400); wr16(4'd8, 16'h090D); wr16(4'd10, 16'h40C3);
    endtask

    initial begin
        #(WDOG * 4);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0]  v;
        logic [15:0] w;

        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        rd(4'd0, v); chk("R1 ctrl after reset", v, 8'h00);
        rd(4'd1, v); chk("R1 addr low after reset", v, 8'h00);
        rd(4'd5, v); chk("R1 data0 high after reset", v, 8'h00);

        // R2 / R11: vector table
        foreach (VECS[i]) begin
            wr(VECS[i].a, VECS[i].d);
            rd(VECS[i].a, v);
            chk(VECS[i].r11 ? "R11 reserved mode / trigger ignored" : "R2 register readback",
                v, VECS[i].e);
        end

        // R3: unlock sequence
        wr(4'd0, 8'hE8);
        rd(4'd0, v); chk("R3 mode-change pending", v, 8'hE8);
        wr16(4'd6, 16'h0400); wr16(4'd8, 16'h090D); wr16(4'd10, 16'h40C3);
        rd(4'd0, v); chk("R3 mode-change cleared", v, 8'hE0);

        // R6: erase page 0x020..0x03F
        set_addr(16'h0020); wr(4'd0, 8'h94);
        rd(4'd0, v); chk("R6 write trigger busy", v, 8'h94);
        poll_clear(2, "R6 erase completes");
        do_read(16'h0020, w); chk("R6 erased first word", w, 16'hFFFF);
        do_read(16'h003F, w); chk("R6 erased last word", w, 16'hFFFF);

        // R7: program and AND behaviour
        do_prog(16'h0021, 16'h5A64);
        do_read(16'h0021, w); chk("R7 program word", w, 16'h5A64);
        do_prog(16'h0021, 16'h0FF0);
        do_read(16'h0021, w); chk("R7 program ANDs", w, 16'h0A60);

        // R9: boundary just below limit accepted, aliased high address ignored
        do_erase(16'h03C0);
        do_prog(16'h03DF, 16'h0000);
        do_read(16'h03DF, w); chk("R9 last usable word", w, 16'h0000);
        do_prog(16'h0421, 16'h0000);
        do_read(16'h0021, w); chk("R9 program above limit ignored", w, 16'h0A60);
        do_erase(16'h0420);
        do_read(16'h0021, w); chk("R9 erase above limit ignored", w, 16'h0A60);

        // R12: read completion collides with bus write to data word 0
        set_addr(16'h0021);
        wr(4'd0, 8'hB3);
        idle(RDC - 1);
        wr(4'd4, 8'h77);
        rd(4'd4, v); chk("R12 read wins low", v, 8'h60);
        rd(4'd5, v); chk("R12 read wins high", v, 8'h0A);

        // R8: read trigger without read enable is ignored
        wr16(4'd4, 16'h1234);
        wr(4'd0, 8'hB1);
        rd(4'd0, v); chk("R8 ignored read trigger", v, 8'hB0);
        idle(RDC + 4);
        rd(4'd4, v); chk("R8 data0 unchanged", v, 8'h34);

        // R10: clearing write enable relocks
        wr(4'd0, 8'h00);
        do_prog(16'h0020, 16'h0000);
        do_read(16'h0020, w); chk("R10 locked program ignored", w, 16'hFFFF);

        // R4: wrong key word
        wr(4'd0, 8'hE8);
        wr16(4'd6, 16'h0400); wr16(4'd8, 16'h090E);
        rd(4'd0, v); chk("R4 wrong key clears pending", v, 8'hE0);
        wr16(4'd10, 16'h40C3);
        do_prog(16'h0020, 16'h0000);
        do_read(16'h0020, w); chk("R4 wrong key stays locked", w, 16'hFFFF);

        // R4: wrong order
        wr(4'd0, 8'hE8);
        wr16(4'd8, 16'h090D); wr16(4'd6, 16'h0400); wr16(4'd10, 16'h40C3);
        do_prog(16'h0020, 16'h0000);
        do_read(16'h0020, w); chk("R4 wrong order stays locked", w, 16'hFFFF);

        // R5: window timeout
        wr(4'd0, 8'hE8);
        wr16(4'd6, 16'h0400); wr16(4'd8, 16'h090D);
        rd(4'd0, v); chk("R5 pending inside window", int'(v[3]), 1);
        idle(WIN + 5);
        rd(4'd0, v); chk("R5 pending cleared by timeout", int'(v[3]), 0);
        wr16(4'd10, 16'h40C3);
        do_prog(16'h0020, 16'h0000);
        do_read(16'h0020, w); chk("R5 late key stays locked", w, 16'hFFFF);

        // R3: a fresh correct unlock opens writes again
        unlock_ok();
        do_prog(16'h0020, 16'h00FF);
        do_read(16'h0020, w); chk("R3 unlocked program", w, 16'h00FF);

        // R11: mode-change trigger in a reserved mode is ignored
        wr(4'd0, 8'hF8);
        rd(4'd0, v); chk("R11 trigger ignored in mode 111", v, 8'hF0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule